// File: doc/BRIEF.md
# Event Fragment Router with Prescaled Monitoring

This block takes formatted event fragments as a stream of 32-bit words. Each word carries a start-of-event and an end-of-event flag. Every word first enters an internal FIFO. What leaves the FIFO goes to one of two places, chosen by a mode input. In data-taking mode every word goes to an outbound link toward the central readout, and that link may push back. In calibration mode the link stays silent and every event goes to a monitoring port that feeds processor memory.

The monitoring port always delivers data in fixed frames of `FRAME_WORDS` beats. If the last frame of an event is short, it is filled out with zero words, and the frame's final beat reports how many of its beats hold real data. In data-taking mode the monitoring port gets a sampled copy of the events, chosen by a programmable prescale. This copy only taps words as they leave the FIFO, so it never holds back the link.

The FIFO's fill level drives a busy output. Busy rises at an upper threshold and falls below a lower one, which tells the trigger source to pause.

Top module: `evr_router`

## Requirements
- R1: With `calib_mode` = 0, every input word leaves on the link in arrival order, with its data and its start and end flags unchanged. A word is transferred on a clock edge where `link_valid` and `link_ready` are both 1.
- R2: With `calib_mode` = 1, `link_valid` stays 0. Every event with a free framer and `mon_ready` = 1 at its start word is delivered on the monitoring port.
- R3: The monitoring port emits frames of exactly `FRAME_WORDS` beats, each beat marked by `mon_valid` for one cycle. `mon_last` is 1 on the final beat of every frame and 0 on all other beats.
- R4: A short final frame is padded with zero-data beats. On the `mon_last` beat, `mon_count` gives the number of real words in the frame (`FRAME_WORDS` for a full frame). On all other beats `mon_count` is 0.
- R5: In data-taking mode with `prescale` = N ≥ 1, an event is selected for monitoring when N−1 events have gone unselected since the last selection or since reset. N = 1 selects every event. N = 0 selects none. Calibration-mode events do not advance this count.
- R6: While `link_ready` is 0, `link_valid` and `link_data` hold the head word and input words gather in the FIFO. After release, all of them leave in order with none lost.
- R7: `busy` rises one cycle after the FIFO fill level reaches or passes `busy_on_level`.
- R8: Once high, `busy` stays high until the fill level drops below `busy_off_level`. It then falls one cycle later.
- R9: A selected event is not captured if, at its start word, `mon_ready` is 0 or the framer is still busy with an earlier frame. In that case it is dropped whole, `mon_drop_count` rises by 1, and the link output is unaffected.
- R10: After reset, `link_valid`, `mon_valid` and `busy` are 0 and `mon_drop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| calib_mode | input | 1 | 0 = data-taking, 1 = calibration |
| prescale | input | PRESCALE_W | Monitoring prescale N (0 = off) |
| busy_on_level | input | LVL_W | Fill level that raises busy |
| busy_off_level | input | LVL_W | Busy falls when fill is below this |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word data |
| in_sof | input | 1 | First word of an event |
| in_eof | input | 1 | Last word of an event |
| link_ready | input | 1 | Link accepts a word (0 = back-pressure) |
| link_valid | output | 1 | Link word present |
| link_data | output | 32 | Link word data |
| link_sof | output | 1 | Link word starts an event |
| link_eof | output | 1 | Link word ends an event |
| mon_ready | input | 1 | Monitoring sink can take a new event |
| mon_valid | output | 1 | Monitoring beat present |
| mon_data | output | 32 | Monitoring beat data (0 for padding) |
| mon_last | output | 1 | Final beat of a frame |
| mon_count | output | CNT_W | Real words in the frame, on the final beat |
| mon_drop_count | output | DROP_W | Number of selected events not captured |
| busy | output | 1 | FIFO fill above threshold, with hysteresis |

## Verification
The hardest case to reach is an event that starts while the framer is still padding the previous frame. A drop from `mon_ready` alone is easy to set up; this one is not. The bench reaches it in calibration mode by sending a one-word event and then, with a single idle cycle between them, a two-word event. With a frame of four beats, the second start word leaves the FIFO while padding is still under way, so the second event must be counted as dropped. Hysteresis is reached by holding the link stalled and stepping the fill level up and down one word at a time under several threshold pairs.

// File: rtl/evr_pkg.sv
package evr_pkg;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic              sof;
        logic              eof;
        logic [WORD_W-1:0] data;
    } evr_word_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_CAP  = 2'd1,
        FR_PAD  = 2'd2
    } fr_state_e;

endpackage

// File: rtl/evr_fifo.sv
module evr_fifo
    import evr_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  evr_word_t       wr_word,
    input  logic            rd_en,
    output evr_word_t       rd_word,
    output logic            empty,
    output logic [LW-1:0]   level
);

    localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);
    localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [LW-1:0] level;
    } fifo_st_t;

    fifo_st_t  st_q, st_d;
    evr_word_t mem_q [DEPTH];
    logic      push, pop;

    always_comb begin
        st_d = st_q;
        push = wr_en && (st_q.level != LVL_MAX);
        pop  = rd_en && (st_q.level != '0);
        if (push) begin
            st_d.wr_ptr = (st_q.wr_ptr == PTR_MAX) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_MAX) ? '0 : st_q.rd_ptr + 1'b1;
        end
        if (push && !pop) begin
            st_d.level = st_q.level + 1'b1;
        end else if (pop && !push) begin
            st_d.level = st_q.level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[st_q.wr_ptr] <= wr_word;
        end
    end

    assign rd_word = mem_q[st_q.rd_ptr];
    assign empty   = (st_q.level == '0);
    assign level   = st_q.level;

endmodule

// File: rtl/evr_busy.sv
module evr_busy #(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] on_level,
    input  logic [LW-1:0] off_level,
    output logic          busy
);

    typedef struct packed {
        logic busy;
    } busy_st_t;

    busy_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.busy = !(level < off_level);
        end else begin
            st_d.busy = (level >= on_level);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

endmodule

// File: rtl/evr_mon_framer.sv
module evr_mon_framer
    import evr_pkg::*;
#(
    parameter int FRAME_WORDS = 256,
    parameter int PRESCALE_W  = 16,
    parameter int DROP_W      = 16,
    localparam int CNT_W      = $clog2(FRAME_WORDS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pop,
    input  evr_word_t             word,
    input  logic                  calib,
    input  logic [PRESCALE_W-1:0] prescale,
    input  logic                  mon_ready,
    output logic                  mon_valid,
    output logic [WORD_W-1:0]     mon_data,
    output logic                  mon_last,
    output logic [CNT_W-1:0]      mon_count,
    output logic [DROP_W-1:0]     drop_count
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_WORDS - 1);

    typedef struct packed {
        fr_state_e             state;
        logic [CNT_W-1:0]      pos;
        logic [CNT_W-1:0]      fill;
        logic [PRESCALE_W-1:0] skip;
        logic [DROP_W-1:0]     drops;
        logic                  vld;
        logic                  last;
        logic [WORD_W-1:0]     data;
        logic [CNT_W-1:0]      count;
    } fr_st_t;

    fr_st_t st_q, st_d;
    logic   start, sel, take, emit;

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.last  = 1'b0;
        st_d.data  = '0;
        st_d.count = '0;

        start = pop && word.sof;
        sel   = 1'b0;
        if (start) begin
            if (calib) begin
                sel = 1'b1;
            end else if (prescale != '0) begin
                if (st_q.skip >= prescale - 1'b1) begin
                    sel       = 1'b1;
                    st_d.skip = '0;
                end else begin
                    st_d.skip = st_q.skip + 1'b1;
                end
            end
        end

        take = sel && mon_ready && (st_q.state == FR_IDLE);
        if (sel && !take) begin
            st_d.drops = st_q.drops + 1'b1;
        end

        emit = take || ((st_q.state == FR_CAP) && pop);
        if (emit) begin
            st_d.vld  = 1'b1;
            st_d.data = word.data;
            if (st_q.pos == LAST_POS) begin
                st_d.last  = 1'b1;
                st_d.count = st_q.fill + 1'b1;
                st_d.pos   = '0;
                st_d.fill  = '0;
                st_d.state = word.eof ? FR_IDLE : FR_CAP;
            end else begin
                st_d.pos   = st_q.pos + 1'b1;
                st_d.fill  = st_q.fill + 1'b1;
                st_d.state = word.eof ? FR_PAD : FR_CAP;
            end
        end else if (st_q.state == FR_PAD) begin
            st_d.vld = 1'b1;
            if (st_q.pos == LAST_POS) begin
                st_d.last  = 1'b1;
                st_d.count = st_q.fill;
                st_d.pos   = '0;
                st_d.fill  = '0;
                st_d.state = FR_IDLE;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mon_valid  = st_q.vld;
    assign mon_data   = st_q.data;
    assign mon_last   = st_q.last;
    assign mon_count  = st_q.count;
    assign drop_count = st_q.drops;

endmodule

// File: rtl/evr_router.sv
module evr_router
    import evr_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int FRAME_WORDS = 256,
    parameter int PRESCALE_W  = 16,
    parameter int DROP_W      = 16,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
    localparam int CNT_W      = $clog2(FRAME_WORDS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  calib_mode,
    input  logic [PRESCALE_W-1:0] prescale,
    input  logic [LVL_W-1:0]      busy_on_level,
    input  logic [LVL_W-1:0]      busy_off_level,
    input  logic                  in_valid,
    input  logic [WORD_W-1:0]     in_data,
    input  logic                  in_sof,
    input  logic                  in_eof,
    input  logic                  link_ready,
    output logic                  link_valid,
    output logic [WORD_W-1:0]     link_data,
    output logic                  link_sof,
    output logic                  link_eof,
    input  logic                  mon_ready,
    output logic                  mon_valid,
    output logic [WORD_W-1:0]     mon_data,
    output logic                  mon_last,
    output logic [CNT_W-1:0]      mon_count,
    output logic [DROP_W-1:0]     mon_drop_count,
    output logic                  busy
);

    evr_word_t        in_word;
    evr_word_t        head;
    logic             fifo_empty;
    logic [LVL_W-1:0] fifo_level;
    logic             head_pop;

    assign in_word = '{sof: in_sof, eof: in_eof, data: in_data};

    assign head_pop   = !fifo_empty && (calib_mode || link_ready);
    assign link_valid = !fifo_empty && !calib_mode;
    assign link_data  = head.data;
    assign link_sof   = head.sof;
    assign link_eof   = head.eof;

    evr_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_word (in_word),
        .rd_en   (head_pop),
        .rd_word (head),
        .empty   (fifo_empty),
        .level   (fifo_level)
    );

    evr_busy #(
        .LW (LVL_W)
    ) u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (fifo_level),
        .on_level  (busy_on_level),
        .off_level (busy_off_level),
        .busy      (busy)
    );

    evr_mon_framer #(
        .FRAME_WORDS (FRAME_WORDS),
        .PRESCALE_W  (PRESCALE_W),
        .DROP_W      (DROP_W)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (head_pop),
        .word       (head),
        .calib      (calib_mode),
        .prescale   (prescale),
        .mon_ready  (mon_ready),
        .mon_valid  (mon_valid),
        .mon_data   (mon_data),
        .mon_last   (mon_last),
        .mon_count  (mon_count),
        .drop_count (mon_drop_count)
    );

endmodule

// File: rtl/evr_router_chk.sv
module evr_router_chk #(
    parameter int FIFO_DEPTH  = 64,
    parameter int FRAME_WORDS = 256,
    parameter int DROP_W      = 16,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
    localparam int CNT_W      = $clog2(FRAME_WORDS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              calib_mode,
    input logic              link_valid,
    input logic              link_ready,
    input logic [31:0]       link_data,
    input logic              mon_valid,
    input logic              mon_last,
    input logic [CNT_W-1:0]  mon_count,
    input logic [DROP_W-1:0] mon_drop_count,
    input logic [LVL_W-1:0]  fifo_level,
    input logic [LVL_W-1:0]  busy_on_level,
    input logic [LVL_W-1:0]  busy_off_level,
    input logic              busy
);

    AST_CALIB_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        calib_mode |-> !link_valid); // R2

    AST_STALL_HOLDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && !link_ready && !calib_mode) |=>
        (calib_mode || (link_valid && $stable(link_data)))); // R6

    AST_LAST_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        mon_last |-> mon_valid); // R3

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mon_last |-> (mon_count != '0 && mon_count <= CNT_W'(FRAME_WORDS))); // R4

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(fifo_level) >= $past(busy_on_level))); // R7

    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(fifo_level) < $past(busy_off_level))); // R8

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mon_drop_count) |-> (mon_drop_count == $past(mon_drop_count) + 1'b1)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(FIFO_DEPTH)); // R6

endmodule

bind evr_router evr_router_chk #(
    .FIFO_DEPTH  (FIFO_DEPTH),
    .FRAME_WORDS (FRAME_WORDS),
    .DROP_W      (DROP_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .calib_mode     (calib_mode),
    .link_valid     (link_valid),
    .link_ready     (link_ready),
    .link_data      (link_data),
    .mon_valid      (mon_valid),
    .mon_last       (mon_last),
    .mon_count      (mon_count),
    .mon_drop_count (mon_drop_count),
    .fifo_level     (fifo_level),
    .busy_on_level  (busy_on_level),
    .busy_off_level (busy_off_level),
    .busy           (busy)
);

// File: tb/tb_evr_router.sv
module tb_evr_router;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int FRAME = 4;
    localparam int PW    = 4;
    localparam int DW    = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int CNT_W = $clog2(FRAME + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              calib_mode = 1'b0;
    logic [PW-1:0]     prescale = '0;
    logic [LVL_W-1:0]  busy_on_level = LVL_W'(DEPTH);
    logic [LVL_W-1:0]  busy_off_level = '0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_data = '0;
    logic              in_sof = 1'b0;
    logic              in_eof = 1'b0;
    logic              link_ready = 1'b1;
    logic              link_valid;
    logic [31:0]       link_data;
    logic              link_sof;
    logic              link_eof;
    logic              mon_ready = 1'b1;
    logic              mon_valid;
    logic [31:0]       mon_data;
    logic              mon_last;
    logic [CNT_W-1:0]  mon_count;
    logic [DW-1:0]     mon_drop_count;
    logic              busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int skip_m = 0;
    int exp_drop = 0;

    logic [33:0] exp_link [$];
    logic [35:0] exp_mon [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    evr_router #(
        .FIFO_DEPTH  (DEPTH),
        .FRAME_WORDS (FRAME),
        .PRESCALE_W  (PW),
        .DROP_W      (DW)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .calib_mode     (calib_mode),
        .prescale       (prescale),
        .busy_on_level  (busy_on_level),
        .busy_off_level (busy_off_level),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_sof         (in_sof),
        .in_eof         (in_eof),
        .link_ready     (link_ready),
        .link_valid     (link_valid),
        .link_data      (link_data),
        .link_sof       (link_sof),
        .link_eof       (link_eof),
        .mon_ready      (mon_ready),
        .mon_valid      (mon_valid),
        .mon_data       (mon_data),
        .mon_last       (mon_last),
        .mon_count      (mon_count),
        .mon_drop_count (mon_drop_count),
        .busy           (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Output observers, sampled well after the falling edge
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            if (link_valid && link_ready) begin
                if (exp_link.size() == 0) begin
                    chk(1'b0, "R1 unexpected link word", {30'd0, link_sof, link_eof, link_data}, 64'd0);
                end else begin
                    logic [33:0] e;
                    e = exp_link.pop_front();
                    chk({link_sof, link_eof, link_data} == e, "R1 link word",
                        {30'd0, link_sof, link_eof, link_data}, {30'd0, e});
                end
            end
            if (calib_mode && link_valid) begin
                chk(1'b0, "R2 link active in calibration", 64'd1, 64'd0);
            end
            if (mon_valid) begin
                if (exp_mon.size() == 0) begin
                    chk(1'b0, "R3 unexpected monitor beat", {28'd0, mon_last, mon_count, mon_data}, 64'd0);
                end else begin
                    logic [35:0] m;
                    m = exp_mon.pop_front();
                    chk({mon_last, mon_count, mon_data} == m, "R3 R4 monitor beat",
                        {28'd0, mon_last, mon_count, mon_data}, {28'd0, m});
                end
            end
        end
    end

    task automatic queue_frames(input int len, input logic [31:0] base);
        int nfr;
        nfr = (len + FRAME - 1) / FRAME;
        for (int f = 0; f < nfr; f++) begin
            for (int k = 0; k < FRAME; k++) begin
                int idx;
                int cnt;
                logic [31:0] d;
                idx = f * FRAME + k;
                d   = (idx < len) ? base + 32'(idx) : 32'd0;
                cnt = 0;
                if (k == FRAME - 1) cnt = ((len - f * FRAME) < FRAME) ? (len - f * FRAME) : FRAME;
                exp_mon.push_back({(k == FRAME - 1), CNT_W'(cnt), d});
            end
        end
    endtask

    // Requirement model for one event: link copy, prescale selection, capture or drop
    task automatic plan_event(input int len, input logic [31:0] base, input bit framer_busy);
        bit sel;
        if (!calib_mode) begin
            for (int i = 0; i < len; i++) begin
                exp_link.push_back({(i == 0), (i == len - 1), base + 32'(i)});
            end
        end
        sel = 1'b0;
        if (calib_mode) begin
            sel = 1'b1;
        end else if (prescale != 0) begin
            if (skip_m >= int'(prescale) - 1) begin
                sel = 1'b1;
                skip_m = 0;
            end else begin
                skip_m++;
            end
        end
        if (sel) begin
            if (mon_ready && !framer_busy) queue_frames(len, base);
            else exp_drop++;
        end
    endtask

    task automatic send_event(input int len, input logic [31:0] base, input bit framer_busy);
        plan_event(len, base, framer_busy);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = base + 32'(i);
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic busy_sweep(input int on_l, input int off_l, input logic [31:0] base);
        int  fill;
        bit  bm;
        fill = 0;
        bm   = 1'b0;
        @(negedge clk);
        busy_on_level  = LVL_W'(on_l);
        busy_off_level = LVL_W'(off_l);
        link_ready     = 1'b0;
        plan_event(7, base, 1'b0);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = base + 32'(i);
            in_sof   = (i == 0);
            in_eof   = (i == 6);
            @(negedge clk);
            in_valid = 1'b0;
            fill++;
            bm = bm ? (fill >= off_l) : (fill >= on_l);
            @(negedge clk);
            #3;
            chk(busy == bm, (bm ? "R7 busy on fill rise" : "R8 busy on fill rise"), 64'(busy), 64'(bm));
            chk(link_valid && link_data == base, "R6 head held under back-pressure",
                {31'd0, link_valid, link_data}, {32'd1, base});
        end
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            link_ready = 1'b1;
            @(negedge clk);
            link_ready = 1'b0;
            fill--;
            bm = bm ? (fill >= off_l) : (fill >= on_l);
            @(negedge clk);
            #3;
            chk(busy == bm, "R8 busy hysteresis on drain", 64'(busy), 64'(bm));
        end
        @(negedge clk);
        link_ready = 1'b1;
        idle(4);
        chk(exp_link.size() == 0, "R6 all stalled words delivered", 64'(exp_link.size()), 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // R10 reset state
        chk(!link_valid && !mon_valid && !busy && mon_drop_count == 0, "R10 reset outputs",
            {link_valid, mon_valid, busy, 32'(mon_drop_count)}, 64'd0);

        // R1 R3 R4: every event captured with prescale 1, lengths around frame size
        prescale = PW'(1);
        send_event(1, 32'h1000, 1'b0); idle(FRAME + 6);
        send_event(3, 32'h1100, 1'b0); idle(FRAME + 6);
        send_event(4, 32'h1200, 1'b0); idle(FRAME + 6);
        send_event(5, 32'h1300, 1'b0); idle(FRAME + 6);
        send_event(8, 32'h1400, 1'b0); idle(FRAME + 6);
        chk(exp_mon.size() == 0, "R4 frames complete", 64'(exp_mon.size()), 64'd0);

        // R5 prescale sweep
        for (int ps = 0; ps < 4; ps++) begin
            prescale = PW'(ps);
            for (int e = 0; e < 6; e++) begin
                send_event((e % 5) + 1, 32'h2000 + 32'(ps * 256 + e * 16), 1'b0);
                idle(FRAME * 2 + 6);
            end
            chk(exp_mon.size() == 0 && exp_link.size() == 0, "R5 prescale selection",
                64'(exp_mon.size() + exp_link.size()), 64'd0);
        end

        // R9 monitor not ready: drop counted, link unaffected
        prescale  = PW'(1);
        mon_ready = 1'b0;
        send_event(3, 32'h3000, 1'b0); idle(FRAME + 6);
        send_event(2, 32'h3100, 1'b0); idle(FRAME + 6);
        mon_ready = 1'b1;
        chk(mon_drop_count == DW'(exp_drop), "R9 drop count when not ready",
            64'(mon_drop_count), 64'(exp_drop));
        chk(exp_link.size() == 0, "R9 link still delivered", 64'(exp_link.size()), 64'd0);

        // R2 calibration mode
        calib_mode = 1'b1;
        send_event(2, 32'h4000, 1'b0); idle(FRAME + 6);
        send_event(4, 32'h4100, 1'b0); idle(FRAME + 6);
        send_event(7, 32'h4200, 1'b0); idle(FRAME * 2 + 6);
        chk(exp_mon.size() == 0, "R2 calibration events on monitor", 64'(exp_mon.size()), 64'd0);

        // R9 start word arrives while the framer is still padding
        send_event(1, 32'h5000, 1'b0);
        send_event(2, 32'h5100, 1'b1);
        idle(FRAME * 2 + 6);
        chk(mon_drop_count == DW'(exp_drop), "R9 drop while padding",
            64'(mon_drop_count), 64'(exp_drop));
        chk(exp_mon.size() == 0, "R4 padded frame delivered", 64'(exp_mon.size()), 64'd0);
        calib_mode = 1'b0;
        idle(4);

        // R6 R7 R8 back-pressure and busy hysteresis
        prescale = '0;
        busy_sweep(5, 2, 32'h6000);
        busy_sweep(3, 3, 32'h6100);
        busy_sweep(7, 1, 32'h6200);

        idle(10);
        chk(exp_link.size() == 0, "R1 link queue empty", 64'(exp_link.size()), 64'd0);
        chk(exp_mon.size() == 0, "R3 monitor queue empty", 64'(exp_mon.size()), 64'd0);
        chk(mon_drop_count == DW'(exp_drop), "R9 final drop count", 64'(mon_drop_count), 64'(exp_drop));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule